// File: doc/BRIEF.md
# Byte Parity Generator and Checker

This block adds byte-granular parity to a 16-bit bidirectional transfer path. It sits after the storage stage of a transceiver core, and each direction hands it an 18-bit stored word: 16 data bits and two parity bits. On the A-to-B side it can work in one of two modes. In generate mode it computes fresh parity for each byte. In check mode it forwards the received parity and tests it. The B-to-A side can only check. A single select picks even or odd parity for both sides at once.

Each direction has one error indication that covers both of its bytes. The indication is an open-drain pull-down. The block drives an enable that is high when the shared flag line should be pulled low, so an external wired-OR can merge it with other sources. A flag can only pull when the output enable (active low) of its own direction is asserted. The block is purely combinational on the stored words, so parity and flags change in the same cycle as the word they describe.

Top module: `bpar_unit`

## Requirements
- R1: Byte lanes are fixed. Data bits [7:0] pair with parity bit [0], and data bits [15:8] pair with parity bit [1], in both directions.
- R2: In A-to-B generate mode (`ab_check_i` = 0) with `odd_sel_i` = 0, each output parity bit is 1 exactly when its data byte holds an odd number of ones.
- R3: In A-to-B generate mode with `odd_sel_i` = 1, each output parity bit is 1 exactly when its data byte holds an even number of ones.
- R4: A checked byte is in error when its 8 data bits plus its received parity bit hold an odd count of ones with `odd_sel_i` = 0, or an even count with `odd_sel_i` = 1.
- R5: A direction's pull enable is 1 when either of its bytes is in error and its output enable is asserted. Otherwise it is 0.
- R6: A pull enable is never 1 while that direction's active-low output enable is high.
- R7: In A-to-B generate mode, `ab_err_pull_o` stays 0 and the value of `ab_par_i` has no effect on any output.
- R8: In A-to-B check mode, `ab_par_o` equals `ab_par_i` whether or not an error is present.
- R9: The B-to-A side always checks. `ba_par_o` always equals `ba_par_i`, and B-to-A error detection works whatever mode the A-to-B side is in.
- R10: Outputs are a pure function of the present inputs and settle in the same cycle that a new stored word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ab_data_i | input | 16 | Stored A-to-B data word |
| ab_par_i | input | 2 | Received A-side parity bits, one per byte |
| ba_data_i | input | 16 | Stored B-to-A data word |
| ba_par_i | input | 2 | Received B-side parity bits, one per byte |
| odd_sel_i | input | 1 | 0 selects even parity, 1 selects odd, for both directions |
| ab_check_i | input | 1 | A-to-B mode: 0 generate, 1 check |
| ab_oe_n_i | input | 1 | A-to-B output enable, active low |
| ba_oe_n_i | input | 1 | B-to-A output enable, active low |
| ab_par_o | output | 2 | Parity bits sent toward B |
| ba_par_o | output | 2 | Parity bits sent toward A |
| ab_err_pull_o | output | 1 | 1 pulls the A-to-B error flag low |
| ba_err_pull_o | output | 1 | 1 pulls the B-to-A error flag low |

## Verification
The bench aims at the lane boundary by placing a single-bit fault in only the upper byte or only the lower byte. A design that swaps or merges lanes would flag the wrong byte, or would miss the fault. It toggles the received A-side parity while in generate mode. A design that lets that pin leak would show changed parity or a spurious flag there. It holds the B-to-A side at an error while A-to-B generates. A design that shares the mode across directions would silence that flag. It also flips the odd/even select with the same data, deasserts each output enable during an error, and replays a wide random mix so that inverted senses or ungated flags show up.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

   // A-to-B operating mode, encoded as seen on ab_check_i
   typedef enum logic {
      AB_MODE_GEN   = 1'b0,
      AB_MODE_CHECK = 1'b1
   } ab_mode_e;

   // parity sense, encoded as seen on odd_sel_i
   typedef enum logic {
      SENSE_EVEN = 1'b0,
      SENSE_ODD  = 1'b1
   } par_sense_e;

   localparam int unsigned DEF_DATA_W = 16;
   localparam int unsigned DEF_LANE_W = 8;

endpackage

// File: rtl/bpar_lane.sv
module bpar_lane #(
   parameter int unsigned LANE_W = 8
) (
   input  logic [LANE_W-1:0] data_i,
   input  logic              rx_par_i,
   input  logic              odd_sel_i,
   output logic              ones_odd_o,
   output logic              err_o
);

   generate
      if (LANE_W < 1) begin : g_bad_width
         $error("bpar_lane: LANE_W must be at least 1");
      end
   endgenerate

   always_comb begin
      ones_odd_o = ^data_i;
      // total ones over data plus parity: odd is bad for even sense, even is bad for odd sense
      err_o      = ones_odd_o ^ rx_par_i ^ odd_sel_i;
   end

endmodule

// File: rtl/bpar_dir.sv
module bpar_dir
   import bpar_pkg::*;
#(
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter int unsigned LANE_W  = DEF_LANE_W,
   parameter bit          CAN_GEN = 1'b1
) (
   input  logic [DATA_W-1:0]        data_i,
   input  logic [DATA_W/LANE_W-1:0] par_i,
   input  logic                     odd_sel_i,
   input  logic                     gen_mode_i,
   input  logic                     oe_n_i,
   output logic [DATA_W/LANE_W-1:0] par_o,
   output logic                     err_pull_o
);

   localparam int unsigned LANES = DATA_W / LANE_W;

   generate
      if ((DATA_W % LANE_W) != 0 || LANES < 1) begin : g_bad_split
         $error("bpar_dir: DATA_W must be a nonzero multiple of LANE_W");
      end
   endgenerate

   logic [LANES-1:0] lane_odd;
   logic [LANES-1:0] lane_err;
   logic             chk_active;
   logic             any_err;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      bpar_lane #(.LANE_W(LANE_W)) u_lane (
         .data_i    (data_i[l*LANE_W +: LANE_W]),
         .rx_par_i  (par_i[l]),
         .odd_sel_i (odd_sel_i),
         .ones_odd_o(lane_odd[l]),
         .err_o     (lane_err[l])
      );
   end

   generate
      if (CAN_GEN) begin : g_gen_capable
         logic [LANES-1:0] gen_par;
         always_comb begin
            gen_par    = lane_odd ^ {LANES{odd_sel_i}};
            chk_active = (gen_mode_i == AB_MODE_CHECK);
            par_o      = chk_active ? par_i : gen_par;
         end
         for (genvar l = 0; l < LANES; l++) begin : g_gen_chk
            // generated bit must make data plus parity meet the chosen sense (R2, R3)
            always_comb begin
               if (!chk_active)
                  p_gen_balances_r2: assert ((^{data_i[l*LANE_W +: LANE_W], par_o[l]}) == odd_sel_i)
                     else $error("generated parity breaks the selected sense");
            end
         end
      end else begin : g_check_only
         // mode input is tied low by the parent; the direction stays in check mode (R9)
         always_comb begin
            chk_active = ~gen_mode_i;
            par_o      = par_i;
         end
         always_comb begin
            p_never_gen_r9: assert (gen_mode_i == 1'b0)
               else $error("check-only side asked to generate");
         end
      end
   endgenerate

   always_comb begin
      any_err    = chk_active & (|lane_err);
      err_pull_o = any_err & ~oe_n_i;
   end

   // a pull requires the direction enabled (R6)
   always_comb begin
      if (err_pull_o)
         p_pull_needs_oe_r6: assert (oe_n_i == 1'b0)
            else $error("flag pulled while output disabled");
   end

   // a pull requires a byte whose count breaks the sense (R5, R4)
   always_comb begin
      if (err_pull_o)
         p_pull_has_cause_r5: assert (|(lane_odd ^ par_i ^ {LANES{odd_sel_i}}))
            else $error("flag pulled with clean bytes");
   end

   // in check mode the received bits leave unchanged (R8)
   always_comb begin
      if (chk_active)
         p_pass_through_r8: assert (par_o == par_i)
            else $error("received parity altered in check mode");
   end

endmodule

// File: rtl/bpar_unit.sv
module bpar_unit
   import bpar_pkg::*;
#(
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter int unsigned LANE_W = DEF_LANE_W
) (
   input  logic [DATA_W-1:0]        ab_data_i,
   input  logic [DATA_W/LANE_W-1:0] ab_par_i,
   input  logic [DATA_W-1:0]        ba_data_i,
   input  logic [DATA_W/LANE_W-1:0] ba_par_i,
   input  logic                     odd_sel_i,
   input  logic                     ab_check_i,
   input  logic                     ab_oe_n_i,
   input  logic                     ba_oe_n_i,
   output logic [DATA_W/LANE_W-1:0] ab_par_o,
   output logic [DATA_W/LANE_W-1:0] ba_par_o,
   output logic                     ab_err_pull_o,
   output logic                     ba_err_pull_o
);

   generate
      if (LANE_W == 0 || (DATA_W % LANE_W) != 0) begin : g_bad_cfg
         $error("bpar_unit: DATA_W must split evenly into LANE_W lanes");
      end
   endgenerate

   // A-to-B: mode chosen by ab_check_i
   bpar_dir #(
      .DATA_W (DATA_W),
      .LANE_W (LANE_W),
      .CAN_GEN(1'b1)
   ) u_ab (
      .data_i    (ab_data_i),
      .par_i     (ab_par_i),
      .odd_sel_i (odd_sel_i),
      .gen_mode_i(ab_check_i),
      .oe_n_i    (ab_oe_n_i),
      .par_o     (ab_par_o),
      .err_pull_o(ab_err_pull_o)
   );

   // B-to-A: check only, shares the parity sense
   bpar_dir #(
      .DATA_W (DATA_W),
      .LANE_W (LANE_W),
      .CAN_GEN(1'b0)
   ) u_ba (
      .data_i    (ba_data_i),
      .par_i     (ba_par_i),
      .odd_sel_i (odd_sel_i),
      .gen_mode_i(1'b0),
      .oe_n_i    (ba_oe_n_i),
      .par_o     (ba_par_o),
      .err_pull_o(ba_err_pull_o)
   );

   // generate mode keeps the A-to-B flag released (R7)
   always_comb begin
      if (ab_check_i == AB_MODE_GEN)
         p_gen_flag_idle_r7: assert (ab_err_pull_o == 1'b0)
            else $error("A-to-B flag pulled in generate mode");
   end

   // B-to-A parity always forwarded (R9)
   always_comb begin
      p_ba_forward_r9: assert (ba_par_o == ba_par_i)
         else $error("B-to-A parity altered");
   end

endmodule

// File: tb/bpar_unit_test.sv
`timescale 1ns/1ps
module bpar_unit_test;

   logic        clk = 1'b0;
   logic [15:0] ab_data = '0;
   logic [1:0]  ab_par  = '0;
   logic [15:0] ba_data = '0;
   logic [1:0]  ba_par  = '0;
   logic        odd_sel = 1'b0;
   logic        ab_chk  = 1'b1;
   logic        ab_oe_n = 1'b1;
   logic        ba_oe_n = 1'b1;
   logic [1:0]  ab_par_q;
   logic [1:0]  ba_par_q;
   logic        ab_pull;
   logic        ba_pull;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;  // 125 MHz

   bpar_unit uut (
      .ab_data_i    (ab_data),
      .ab_par_i     (ab_par),
      .ba_data_i    (ba_data),
      .ba_par_i     (ba_par),
      .odd_sel_i    (odd_sel),
      .ab_check_i   (ab_chk),
      .ab_oe_n_i    (ab_oe_n),
      .ba_oe_n_i    (ba_oe_n),
      .ab_par_o     (ab_par_q),
      .ba_par_o     (ba_par_q),
      .ab_err_pull_o(ab_pull),
      .ba_err_pull_o(ba_pull)
   );

   function automatic int count_ones(input logic [7:0] b);
      int n = 0;
      for (int i = 0; i < 8; i++) if (b[i]) n++;
      return n;
   endfunction

   // behavioural reference: byte k covers data[8k+7:8k] and parity[k]
   function automatic logic ref_gen(input logic [7:0] b, input logic sel);
      int n = count_ones(b);
      return sel ? ((n % 2) == 0) : ((n % 2) == 1);
   endfunction

   function automatic logic ref_bad(input logic [7:0] b, input logic p, input logic sel);
      int n = count_ones(b) + (p ? 1 : 0);
      return sel ? ((n % 2) == 0) : ((n % 2) == 1);
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // compare every output against the model; inputs were set after the previous edge
   task automatic compare(input string ctx);
      logic [1:0] e_ab_par;
      logic       e_ab_pull, e_ba_pull, ab_any, ba_any;
      ab_any = 1'b0;
      ba_any = 1'b0;
      for (int k = 0; k < 2; k++) begin
         e_ab_par[k] = ab_chk ? ab_par[k] : ref_gen(ab_data[8*k +: 8], odd_sel);
         if (ref_bad(ab_data[8*k +: 8], ab_par[k], odd_sel)) ab_any = 1'b1;
         if (ref_bad(ba_data[8*k +: 8], ba_par[k], odd_sel)) ba_any = 1'b1;
      end
      e_ab_pull = ab_chk && ab_any && !ab_oe_n;
      e_ba_pull = ba_any && !ba_oe_n;
      if (ab_chk) check({ctx, " R8 ab_par"}, ab_par_q, e_ab_par);
      else        check({ctx, (odd_sel ? " R3" : " R2"), " ab_par"}, ab_par_q, e_ab_par);
      check({ctx, " R9 ba_par"}, ba_par_q, ba_par);
      if (!ab_chk) check({ctx, " R7 ab_pull"}, ab_pull, 0);
      else if (ab_oe_n) check({ctx, " R6 ab_pull"}, ab_pull, 0);
      else check({ctx, " R4 R5 ab_pull"}, ab_pull, e_ab_pull);
      if (ba_oe_n) check({ctx, " R6 ba_pull"}, ba_pull, 0);
      else check({ctx, " R9 R5 ba_pull"}, ba_pull, e_ba_pull);
   endtask

   task automatic apply(input logic [15:0] ad, input logic [1:0] ap,
                        input logic [15:0] bd, input logic [1:0] bp,
                        input logic sel, input logic chk,
                        input logic aoe_n, input logic boe_n, input string ctx);
      @(posedge clk);
      #1;
      ab_data = ad; ab_par = ap; ba_data = bd; ba_par = bp;
      odd_sel = sel; ab_chk = chk; ab_oe_n = aoe_n; ba_oe_n = boe_n;
      @(negedge clk);
      compare(ctx);
   endtask

   bit done = 1'b0;

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // quiet state after start-up: both outputs disabled
      @(negedge clk);
      check("start R6 ab_pull", ab_pull, 0);
      check("start R6 ba_pull", ba_pull, 0);
      check("start R8 ab_par", ab_par_q, 0);

      // generation, even sense: low byte one bit set, high byte two bits
      apply(16'h0301, 2'b00, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "gen even");
      check("gen even R2 R1 ab_par", ab_par_q, 2'b01);
      // same data, odd sense
      apply(16'h0301, 2'b00, 16'h0000, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, "gen odd");
      check("gen odd R3 R1 ab_par", ab_par_q, 2'b10);
      // received A parity toggled in generate mode has no effect
      apply(16'h0301, 2'b11, 16'h0000, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, "gen ignore");
      check("gen ignore R7 ab_par", ab_par_q, 2'b10);
      check("gen ignore R7 ab_pull", ab_pull, 0);

      // check mode, even sense: fault only in upper byte
      apply(16'h0100, 2'b00, 16'h0000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, "upper fault");
      check("upper fault R1 R5 ab_pull", ab_pull, 1);
      check("upper fault R8 ab_par", ab_par_q, 2'b00);
      // fault only in lower byte via parity bit
      apply(16'h0000, 2'b01, 16'h0000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, "lower fault");
      check("lower fault R4 R5 ab_pull", ab_pull, 1);
      check("lower fault R8 ab_par", ab_par_q, 2'b01);
      // clean even-sense word
      apply(16'h0101, 2'b11, 16'h0000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, "clean even");
      check("clean even R4 ab_pull", ab_pull, 0);
      // same word, odd sense: both bytes bad
      apply(16'h0101, 2'b11, 16'h0000, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, "flip sense");
      check("flip sense R4 ab_pull", ab_pull, 1);
      // error present but output disabled
      apply(16'h0100, 2'b00, 16'h0000, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, "oe off");
      check("oe off R6 ab_pull", ab_pull, 0);

      // B-to-A error while A-to-B generates
      apply(16'h00FF, 2'b00, 16'h8000, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, "ba during gen");
      check("ba during gen R9 ba_pull", ba_pull, 0);
      apply(16'h00FF, 2'b00, 16'h8000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "ba fault");
      check("ba fault R9 ba_pull", ba_pull, 1);
      check("ba fault R9 ba_par", ba_par_q, 2'b00);
      apply(16'h00FF, 2'b00, 16'h8000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "ba oe off");
      check("ba oe off R6 ba_pull", ba_pull, 0);

      // same-cycle response: new word right after a clean one
      apply(16'h0000, 2'b00, 16'h0000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, "settle a");
      apply(16'h0001, 2'b00, 16'h0000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, "settle b");
      check("settle R10 ab_pull", ab_pull, 1);

      // broad random mix
      for (int i = 0; i < 2000; i++) begin
         logic [31:0] r0, r1;
         r0 = $urandom;
         r1 = $urandom;
         apply(r0[15:0], r1[1:0], r0[31:16], r1[3:2], r1[4], r1[5],
               (r1[7:6] == 2'b11), (r1[9:8] == 2'b11), "random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule